// File: doc/BRIEF.md
# Song Sequencer Control and Datapath

This block plays a stored song. A requester names one of 32 songs with a 5-bit number and a valid/ready handshake. The sequencer then walks through that song's note words in a memory that answers reads in the same cycle. Each word that is not the end marker goes to a downstream multi-note player over a second valid/ready channel. When the end marker is read, the sequencer goes back to idle and accepts a new song.

Songs sit at a fixed stride of 0x200 bytes, which is 128 four-byte words each. The start byte address of a song is the song number shifted left by nine. The low three bits of a note word select the note: 0 is a rest, and 1 to 7 are G, A, B, C, D, E and F. A word whose low 16 bits are 0xFFFF ends the song.

Control is a four-state Mealy machine with fixed codes: reset 00, idle 01, fetch 10 and wait 11. It drives a loadable byte-address counter and reads an end-marker comparator.

Top module: `song_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the block is in the reset state (code 00). In that state `song_req_rdy`, `mem_rd_val` and `note_req_val` are low and `mem_rd_addr` is 0. From the second cycle after release the block is idle and `song_req_rdy` is high.
- R2: `song_req_rdy` is high only in the idle state. Whenever it is high, `mem_rd_val` and `note_req_val` are low.
- R3: A song handshake (`song_req_val` and `song_req_rdy` both high) makes the next cycle a fetch. In that cycle `mem_rd_val` is high and `mem_rd_addr` = {2'b0, song number, 9'b0}, which is the song number times 0x200.
- R4: `mem_rd_val` is high only in the fetch state. The address holds its value across any cycle in which it is neither loaded (idle) nor stepped (a note handshake).
- R5: If the fetched word has low 16 bits equal to 0xFFFF, `note_req_val` stays low and `song_req_rdy` is high on the next cycle. A song whose first word is the marker plays no note.
- R6: A fetched word that is not the marker raises `note_req_val` with `note_req_num` = word bits [2:0]. On the note handshake, the next cycle has `mem_rd_val` low and an address 4 higher.
- R7: If `note_req_rdy` is low during a fetch, the fetch repeats on the next cycle at the same address.
- R8: After a note handshake no fetch is made while `note_req_rdy` is low. A fetch follows in the cycle after `note_req_rdy` is seen high.
- R9: Bits [31:16] of the read data affect neither the end decision nor the note number.
- R10: `song_req_val` has no effect while a song is playing. `song_req_rdy` stays low and the fetch addresses are unchanged.
- R11: A song that fills all 128 words with no marker fetches next at the following song's base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| song_req_val | input | 1 | Song request valid |
| song_req_num | input | 5 | Song number to play |
| song_req_rdy | output | 1 | Ready for a new song (idle) |
| mem_rd_val | output | 1 | Memory read valid |
| mem_rd_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 32 | Read data, same cycle |
| note_req_val | output | 1 | Note request valid |
| note_req_num | output | 3 | Note number (0 rest, 1..7 notes) |
| note_req_rdy | input | 1 | Note player ready |

## Verification
The hardest case to reach from the ports is a fetch that sees the player not ready. The player only asserts ready after it finishes a note, so this normally cannot occur. The bench's player model has a stall control that holds ready low before a song starts. The first fetch then meets a busy player, and the bench checks that the fetch repeats at an unchanged address until ready returns. A 128-word song with no marker, played with a zero-duration player, reaches the boundary where the next fetch lands on the next song's base.

// File: rtl/song_seq_pkg.sv
package song_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_RESET = 2'b00,
        SEQ_IDLE  = 2'b01,
        SEQ_PLAY  = 2'b10,
        SEQ_WAIT  = 2'b11
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/song_addr_ctr.sv
module song_addr_ctr #(
    parameter int ADDR_W = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_regs_t;

    ctr_regs_t cur_q;
    ctr_regs_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_en) begin
            nxt_d.addr = load_val;
        end else if (step_en) begin
            nxt_d.addr = cur_q.addr + STEP_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr = cur_q.addr;

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && step_en)); // R4

endmodule

// File: rtl/song_end_cmp.sv
module song_end_cmp #(
    parameter int                CMP_W    = 16,
    parameter logic [CMP_W-1:0]  END_CODE = '1
) (
    input  logic [CMP_W-1:0] word_lo,
    output logic             is_end
);

    always_comb begin
        is_end = (word_lo == END_CODE);
    end

endmodule

// File: rtl/song_seq_fsm.sv
module song_seq_fsm
    import song_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic song_val,
    input  logic note_rdy,
    input  logic is_end,
    output logic song_rdy,
    output logic mem_val,
    output logic note_val,
    output logic addr_load,
    output logic addr_step
);

    seq_regs_t cur_q;
    seq_regs_t nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        song_rdy  = 1'b0;
        mem_val   = 1'b0;
        note_val  = 1'b0;
        addr_load = 1'b0;
        addr_step = 1'b0;
        unique case (cur_q.state)
            SEQ_RESET: begin
                nxt_d.state = SEQ_IDLE;
            end
            SEQ_IDLE: begin
                song_rdy  = 1'b1;
                addr_load = 1'b1;
                if (song_val) begin
                    nxt_d.state = SEQ_PLAY;
                end
            end
            SEQ_PLAY: begin
                mem_val = 1'b1;
                if (is_end) begin
                    nxt_d.state = SEQ_IDLE;
                end else begin
                    note_val = 1'b1;
                    if (note_rdy) begin
                        addr_step   = 1'b1;
                        nxt_d.state = SEQ_WAIT;
                    end
                end
            end
            SEQ_WAIT: begin
                if (note_rdy) begin
                    nxt_d.state = SEQ_PLAY;
                end
            end
            default: begin
                nxt_d.state = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= SEQ_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == SEQ_RESET) |=> (cur_q.state == SEQ_IDLE)); // R1

    AST_RDY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        song_rdy |-> (!mem_val && !note_val)); // R2

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == SEQ_WAIT) && !note_rdy) |=> !mem_val); // R8

    AST_WAIT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == SEQ_WAIT) && note_rdy) |=> mem_val); // R8

endmodule

// File: rtl/song_seq.sv
module song_seq #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int SONG_W     = 5,
    parameter int NOTE_W     = 3,
    parameter int SONG_SHIFT = 9,
    parameter int WORD_BYTES = 4,
    parameter int CMP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              song_req_val,
    input  logic [SONG_W-1:0] song_req_num,
    output logic              song_req_rdy,
    output logic              mem_rd_val,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              note_req_val,
    output logic [NOTE_W-1:0] note_req_num,
    input  logic              note_req_rdy
);

    localparam int               PAD_W   = ADDR_W - SONG_W - SONG_SHIFT;
    localparam logic [CMP_W-1:0] END_VAL = '1;

    logic [ADDR_W-1:0] start_addr;
    logic              is_end;
    logic              addr_load;
    logic              addr_step;
    logic              unused_hi;

    assign start_addr   = {{PAD_W{1'b0}}, song_req_num, {SONG_SHIFT{1'b0}}};
    assign note_req_num = mem_rd_data[NOTE_W-1:0];
    assign unused_hi    = ^mem_rd_data[DATA_W-1:CMP_W];

    song_end_cmp #(
        .CMP_W    (CMP_W),
        .END_CODE (END_VAL)
    ) u_end_cmp (
        .word_lo (mem_rd_data[CMP_W-1:0]),
        .is_end  (is_end)
    );

    song_addr_ctr #(
        .ADDR_W (ADDR_W),
        .STEP   (WORD_BYTES)
    ) u_addr_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (addr_load),
        .load_val (start_addr),
        .step_en  (addr_step),
        .addr     (mem_rd_addr)
    );

    song_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .song_val  (song_req_val),
        .note_rdy  (note_req_rdy),
        .is_end    (is_end),
        .song_rdy  (song_req_rdy),
        .mem_val   (mem_rd_val),
        .note_val  (note_req_val),
        .addr_load (addr_load),
        .addr_step (addr_step)
    );

    AST_SONG_START: assert property (@(posedge clk) disable iff (!rst_n)
        (song_req_val && song_req_rdy) |=> (mem_rd_val && (mem_rd_addr == $past(start_addr)))); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_val && !song_req_rdy) |=> $stable(mem_rd_addr)); // R4

    AST_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_val && (mem_rd_data[CMP_W-1:0] == END_VAL)) |-> !note_req_val); // R5

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_val && (mem_rd_data[CMP_W-1:0] == END_VAL)) |=> song_req_rdy); // R5

    AST_NOTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (note_req_val && note_req_rdy) |=>
            (!mem_rd_val && (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(WORD_BYTES)))); // R6

    AST_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (note_req_val && !note_req_rdy) |=> (mem_rd_val && $stable(mem_rd_addr))); // R7

    AST_LOW_BITS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_val && (mem_rd_data[CMP_W-1:0] != END_VAL)) |-> note_req_val); // R9

endmodule

// File: tb/song_seq_bench.sv
module song_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int DONE_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        song_req_val = 1'b0;
    logic [4:0]  song_req_num = '0;
    logic        song_req_rdy;
    logic        mem_rd_val;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        note_req_val;
    logic [2:0]  note_req_num;
    logic        note_req_rdy;

    always #(CLK_PERIOD/2) clk = ~clk;

    song_seq u_song_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .song_req_val (song_req_val),
        .song_req_num (song_req_num),
        .song_req_rdy (song_req_rdy),
        .mem_rd_val   (mem_rd_val),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .note_req_val (note_req_val),
        .note_req_num (note_req_num),
        .note_req_rdy (note_req_rdy)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] store [int];
    logic [31:0] tune [$];
    logic [18:0] expq [$];

    function automatic logic [31:0] fetch(input logic [15:0] a);
        int idx;
        idx = int'(a >> 2);
        if (store.exists(idx)) return store[idx];
        return 32'h0000_FFFF;
    endfunction

    always_comb mem_rd_data = fetch(mem_rd_addr);

    int   note_dur = 2;
    logic stall = 1'b0;
    int   busy = 0;

    assign note_req_rdy = (busy == 0) && !stall;

    always @(posedge clk) begin
        if (!rst_n) busy <= 0;
        else if (note_req_val && note_req_rdy) busy <= note_dur;
        else if (busy > 0) busy <= busy - 1;
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: places a song in memory and pushes the expected note stream
    task automatic load_song(input int song);
        int base;
        bit ended;
        base  = song * 128;
        ended = 1'b0;
        for (int i = 0; i < tune.size(); i++) begin
            store[base + i] = tune[i];
            if (tune[i][15:0] == 16'hFFFF) begin
                ended = 1'b1;
                break;
            end
            expq.push_back({16'(song * 512 + i * 4), tune[i][2:0]});
        end
        if (!ended) store[base + tune.size()] = 32'h0000_FFFF;
    endtask

    task automatic start_song(input int song);
        int n;
        n = 0;
        @(negedge clk);
        while (!song_req_rdy && n < DONE_LIMIT) begin
            @(negedge clk);
            n++;
        end
        @(posedge clk);
        #1;
        song_req_val = 1'b1;
        song_req_num = 5'(song);
        @(posedge clk);
        #1;
        song_req_val = 1'b0;
        @(negedge clk);
        check_eq("R3", "fetch valid after start", 32'(mem_rd_val), 32'd1);
        check_eq("R3", "start address", 32'(mem_rd_addr), 32'(song * 512));
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (!song_req_rdy && n < DONE_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check_eq(req, "back to idle", 32'(song_req_rdy), 32'd1);
        check_eq(req, "notes left unplayed", 32'(expq.size()), 32'd0);
        expq.delete();
    endtask

    // monitor: scoreboard plus per-cycle protocol checks
    logic        seen_idle = 1'b0;
    logic        prev_wait = 1'b0;
    logic        prev_nrdy = 1'b0;
    logic [15:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (song_req_rdy) begin
                check_eq("R2", "fetch while idle", 32'(mem_rd_val), 32'd0);
                check_eq("R2", "note while idle", 32'(note_req_val), 32'd0);
            end
            if (note_req_val && note_req_rdy) begin
                if (expq.size() == 0) begin
                    check_eq("R6", "unexpected note at addr", 32'(mem_rd_addr), 32'hFFFF_FFFF);
                end else begin
                    logic [18:0] e;
                    e = expq.pop_front();
                    check_eq("R6", "note address", 32'(mem_rd_addr), 32'(e[18:3]));
                    check_eq("R6", "note number", 32'(note_req_num), 32'(e[2:0]));
                end
            end
            if (prev_wait) begin
                check_eq("R4", "address held", 32'(mem_rd_addr), 32'(prev_addr));
                check_eq("R8", "fetch after wait", 32'(mem_rd_val), 32'(prev_nrdy));
            end
            if (song_req_rdy) seen_idle = 1'b1;
            prev_wait = seen_idle && !mem_rd_val && !song_req_rdy;
            prev_nrdy = note_req_rdy;
            prev_addr = mem_rd_addr;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset behaviour
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "ready in reset", 32'(song_req_rdy), 32'd0);
        check_eq("R1", "fetch in reset", 32'(mem_rd_val), 32'd0);
        check_eq("R1", "address in reset", 32'(mem_rd_addr), 32'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready first cycle", 32'(song_req_rdy), 32'd0);
        check_eq("R1", "note first cycle", 32'(note_req_val), 32'd0);
        @(negedge clk);
        check_eq("R1", "ready second cycle", 32'(song_req_rdy), 32'd1);

        // R3 R6: ordinary song with a trailing rest
        tune = '{32'd3, 32'd2, 32'd1, 32'd2, 32'd3, 32'd3, 32'd3, 32'd0, 32'h0000_FFFF};
        load_song(0);
        start_song(0);
        wait_done("R6");

        // R9: upper bits ignored for notes and the end marker
        tune = '{32'h1234_0005, 32'h0000_FFFE, 32'h8000_0007, 32'hABCD_FFFF};
        load_song(31);
        start_song(31);
        wait_done("R9");

        // R5: empty song
        tune = '{32'h0000_FFFF};
        load_song(5);
        start_song(5);
        check_eq("R5", "no note on marker", 32'(note_req_val), 32'd0);
        @(negedge clk);
        check_eq("R5", "idle after marker", 32'(song_req_rdy), 32'd1);
        wait_done("R5");

        // R7: player busy at the first fetch
        @(posedge clk);
        #1;
        stall = 1'b1;
        tune = '{32'd1, 32'd4, 32'h0000_FFFF};
        load_song(7);
        start_song(7);
        check_eq("R7", "note offered while stalled", 32'(note_req_val), 32'd1);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check_eq("R7", "fetch repeats", 32'(mem_rd_val), 32'd1);
            check_eq("R7", "fetch address", 32'(mem_rd_addr), 32'h0000_0E00);
        end
        @(posedge clk);
        #1;
        stall = 1'b0;
        wait_done("R7");

        // R8 R10: long notes, song request held during playback
        note_dur = 8;
        tune = '{32'd6, 32'd5, 32'd4, 32'd3, 32'h0000_FFFF};
        load_song(2);
        start_song(2);
        @(posedge clk);
        #1;
        song_req_val = 1'b1;
        song_req_num = 5'd9;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check_eq("R10", "ready while playing", 32'(song_req_rdy), 32'd0);
        end
        @(posedge clk);
        #1;
        song_req_val = 1'b0;
        wait_done("R10");

        // R11: full 128-word song, instant player
        note_dur = 0;
        tune.delete();
        for (int i = 0; i < 128; i++) tune.push_back(32'(i % 8));
        load_song(3);
        start_song(3);
        begin
            int n;
            n = 0;
            while (!(mem_rd_val && mem_rd_addr == 16'h0800) && n < DONE_LIMIT) begin
                @(negedge clk);
                n++;
            end
        end
        check_eq("R11", "fetch at next base", 32'(mem_rd_addr), 32'h0000_0800);
        check_eq("R11", "no note at next base", 32'(note_req_val), 32'd0);
        wait_done("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule